// File: doc/BRIEF.md
# Interrupt Daisy-Chain Node with Downstream Disable

This block is one link in a priority chain of interrupt sources. Each source sits between a higher-priority neighbour, which drives its enable-in, and a lower-priority neighbour, which receives its enable-out. Outside acknowledge cycles the chain is shaped only by the under-service flag. The request's pending flag joins the chain only while an acknowledge cycle is running. Because of this, no node has to watch the instruction stream for a return-from-interrupt. Service ends when software issues an explicit reset-service command.

A command port takes one operation per clock. The operations are: write the control bits (master interrupt enable and downstream disable), reset the under-service flag, and clear the pending flag. Setting the downstream-disable bit holds enable-out low whatever the interrupt state is. Software can use this to cut off every source below this node. The internal request is a level held by its source. It is captured into the pending flag outside acknowledge cycles. While an acknowledge cycle runs, the pending flag is frozen so that the chain can settle.

Top module: `irq_chain_node`

## Requirements
- R1: After reset the pending, under-service, master-enable and downstream-disable bits are all clear. So int_no_o is high, vec_oe_o is low, ius_o is low, and eout_o equals ein_i.
- R2: With iack_i low and ein_i low, eout_o is low.
- R3: With iack_i low, ein_i high and downstream disable clear, eout_o is the inverse of ius_o. The pending flag has no effect.
- R4: With iack_i high, ein_i high and downstream disable clear, eout_o is high only when both the pending and under-service flags are clear.
- R5: With iack_i high and ein_i low, eout_o is low and vec_oe_o stays low.
- R6: Command op 1 writes the control bits: cmd_data_i[0] is master enable and cmd_data_i[1] is downstream disable. While downstream disable is set, eout_o is low in every state. Clearing it restores the normal chain.
- R7: int_no_o is low exactly when master enable is set, pending is set, ius_o is low and ein_i is high.
- R8: vec_oe_o is high exactly when iack_i, iack_rd_i and ein_i are high and pending is set.
- R9: If vec_oe_o was high at any clock edge of an acknowledge cycle, ius_o goes high after the first edge that samples iack_i low. ius_o never rises any other way.
- R10: Command op 2 clears ius_o on the next edge; a cycle-end set on the same edge wins. No other input clears it, and no instruction on any bus is decoded.
- R11: The pending flag is set at an edge where req_i is high and iack_i is low. Command op 3 clears it at an edge where iack_i and req_i are both low, and the request wins when both occur on the same edge. Command op 0 does nothing.
- R12: At any edge where iack_i is high, the pending flag keeps its value. Requests and clear commands made during that edge are not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ein_i | input | 1 | Chain enable from the higher-priority neighbour |
| req_i | input | 1 | Internal interrupt request, level |
| iack_i | input | 1 | Acknowledge cycle in progress |
| iack_rd_i | input | 1 | Vector read strobe inside an acknowledge cycle |
| cmd_we_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command: 0 none, 1 write control, 2 reset service, 3 clear pending |
| cmd_data_i | input | 2 | Control bits for op 1: [1] downstream disable, [0] master enable |
| eout_o | output | 1 | Chain enable to the lower-priority neighbour |
| int_no_o | output | 1 | Interrupt request, active low |
| vec_oe_o | output | 1 | Vector output enable |
| ius_o | output | 1 | Under-service flag |

## Verification
The bench visits every row of the idle and acknowledge chain tables. A node that let the pending flag into the idle chain would drop eout_o for a pending but unserviced request. A node that left it out during acknowledge would let a lower device win arbitration. The bench issues requests and clear commands in the middle of an acknowledge cycle; a node without the freeze would change eout_o and vec_oe_o while the chain is settling. It also checks that the service flag rises only after the cycle ends and that it clears only on the reset-service command. Randomised traffic puts the reset-service command on the same edge as a cycle end and sets downstream disable during acknowledge, where a wrong priority would show up as an incorrect eout_o or ius_o.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  localparam int OP_W   = 2;
  localparam int CTRL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 2'd0,
    OP_WR_CTRL  = 2'd1,
    OP_RST_IUS  = 2'd2,
    OP_CLR_PEND = 2'd3
  } irqn_op_e;

  typedef struct packed {
    logic dlc;  // downstream disable
    logic mie;  // master enable
  } irqn_ctrl_t;
endpackage

// File: rtl/irqn_cmd.sv
module irqn_cmd
  import irqn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [CTRL_W-1:0] cmd_data_i,
  output irqn_ctrl_t        ctrl_o,
  output logic              rst_ius_o,
  output logic              clr_pend_o
);
  irqn_op_e op;
  assign op = irqn_op_e'(cmd_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (cmd_we_i && op == OP_WR_CTRL) begin
      ctrl_o <= irqn_ctrl_t'(cmd_data_i);
    end
  end

  assign rst_ius_o  = cmd_we_i && (op == OP_RST_IUS);
  assign clr_pend_o = cmd_we_i && (op == OP_CLR_PEND);
endmodule

// File: rtl/irqn_flags.sv
module irqn_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic iack_i,
  input  logic win_i,
  input  logic rst_ius_i,
  input  logic clr_pend_i,
  output logic pend_o,
  output logic ius_o
);
  logic iack_q, win_q, cyc_end;

  assign cyc_end = iack_q && !iack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_q <= 1'b0;
      win_q  <= 1'b0;
      pend_o <= 1'b0;
      ius_o  <= 1'b0;
    end else begin
      iack_q <= iack_i;
      win_q  <= iack_i ? (win_q || win_i) : 1'b0;
      // pending frozen while the chain settles
      if (!iack_i) begin
        if (req_i)           pend_o <= 1'b1;
        else if (clr_pend_i) pend_o <= 1'b0;
      end
      if (cyc_end && win_q)  ius_o <= 1'b1;
      else if (rst_ius_i)    ius_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irqn_chain.sv
module irqn_chain
  import irqn_pkg::*;
(
  input  logic       ein_i,
  input  logic       iack_i,
  input  logic       iack_rd_i,
  input  logic       pend_i,
  input  logic       ius_i,
  input  irqn_ctrl_t ctrl_i,
  output logic       eout_o,
  output logic       int_no_o,
  output logic       vec_oe_o
);
  logic busy;

  // pending joins the chain only inside an acknowledge cycle
  assign busy     = ius_i || (iack_i && pend_i);
  assign eout_o   = ein_i && !busy && !ctrl_i.dlc;
  assign int_no_o = !(ctrl_i.mie && pend_i && !ius_i && ein_i);
  assign vec_oe_o = iack_i && iack_rd_i && ein_i && pend_i;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irqn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ein_i,
  input  logic              req_i,
  input  logic              iack_i,
  input  logic              iack_rd_i,
  input  logic              cmd_we_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [CTRL_W-1:0] cmd_data_i,
  output logic              eout_o,
  output logic              int_no_o,
  output logic              vec_oe_o,
  output logic              ius_o
);
  irqn_ctrl_t ctrl;
  logic rst_ius, clr_pend, pend;

  irqn_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (cmd_we_i),
    .cmd_op_i   (cmd_op_i),
    .cmd_data_i (cmd_data_i),
    .ctrl_o     (ctrl),
    .rst_ius_o  (rst_ius),
    .clr_pend_o (clr_pend)
  );

  irqn_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .iack_i     (iack_i),
    .win_i      (vec_oe_o),
    .rst_ius_i  (rst_ius),
    .clr_pend_i (clr_pend),
    .pend_o     (pend),
    .ius_o      (ius_o)
  );

  irqn_chain u_chain (
    .ein_i      (ein_i),
    .iack_i     (iack_i),
    .iack_rd_i  (iack_rd_i),
    .pend_i     (pend),
    .ius_i      (ius_o),
    .ctrl_i     (ctrl),
    .eout_o     (eout_o),
    .int_no_o   (int_no_o),
    .vec_oe_o   (vec_oe_o)
  );
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk
  import irqn_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ein_i,
  input logic            iack_i,
  input logic            cmd_we_i,
  input logic [OP_W-1:0] cmd_op_i,
  input logic            eout_o,
  input logic            int_no_o,
  input logic            vec_oe_o,
  input logic            ius_o,
  input logic            pend,
  input irqn_ctrl_t      ctrl
);
  // R2
  ein_low_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ein_i |-> !eout_o);
  // R4
  ack_busy_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && (pend || ius_o)) |-> !eout_o);
  // R6
  dlc_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.dlc |-> !eout_o);
  // R7
  int_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no_o |-> (ein_i && !ius_o && ctrl.mie));
  // R8
  vec_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (iack_i && ein_i && pend));
  // R9
  ius_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ius_o) |-> (!$past(iack_i) && $past(iack_i, 2)));
  // R10
  ius_clear_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ius_o) |-> $past(cmd_we_i && cmd_op_i == OP_RST_IUS));
  // R12
  pend_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(iack_i) |-> $stable(pend));
endmodule

bind irq_chain_node irq_chain_node_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ein_i    (ein_i),
  .iack_i   (iack_i),
  .cmd_we_i (cmd_we_i),
  .cmd_op_i (cmd_op_i),
  .eout_o   (eout_o),
  .int_no_o (int_no_o),
  .vec_oe_o (vec_oe_o),
  .ius_o    (ius_o),
  .pend     (pend),
  .ctrl     (ctrl)
);

// File: tb/irq_chain_node_bench.sv
module irq_chain_node_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ein = 1'b0, req = 1'b0, iack = 1'b0, rd = 1'b0, we = 1'b0;
  logic [1:0] op = 2'd0, dat = 2'd0;
  logic eout, int_n, vec_oe, ius;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // reference state
  logic m_mie = 0, m_dlc = 0, m_pend = 0, m_ius = 0, m_win = 0, m_iackq = 0;
  logic m_ius_clr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_node u_irq_chain_node (
    .clk_i(clk), .rst_ni(rst_n), .ein_i(ein), .req_i(req), .iack_i(iack),
    .iack_rd_i(rd), .cmd_we_i(we), .cmd_op_i(op), .cmd_data_i(dat),
    .eout_o(eout), .int_no_o(int_n), .vec_oe_o(vec_oe), .ius_o(ius)
  );

  function automatic logic f_eout();
    if (m_dlc) return 1'b0;
    if (iack)  return ein && !m_pend && !m_ius;
    return ein && !m_ius;
  endfunction

  function automatic string f_eout_tag();
    if (m_dlc) return "R6";
    if (iack)  return ein ? "R4" : "R5";
    return ein ? "R3" : "R2";
  endfunction

  function automatic logic f_int_n();
    return !(m_mie && m_pend && !m_ius && ein);
  endfunction

  function automatic logic f_vec();
    return iack && rd && ein && m_pend;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic auto_check();
    chk(f_eout_tag(), "eout", eout, f_eout());
    chk("R7", "int_n", int_n, f_int_n());
    chk("R8", "vec_oe", vec_oe, f_vec());
    chk(m_ius_clr ? "R10" : "R9", "ius", ius, m_ius);
  endtask

  task automatic model_update();
    logic ends;
    ends = m_iackq && !iack;
    m_ius_clr = 1'b0;
    if (ends && m_win) m_ius = 1'b1;
    else if (we && op == 2'd2) begin
      m_ius_clr = m_ius;
      m_ius = 1'b0;
    end
    m_win = iack ? (m_win || f_vec()) : 1'b0;
    if (!iack) begin
      if (req) m_pend = 1'b1;
      else if (we && op == 2'd3) m_pend = 1'b0;
    end
    if (we && op == 2'd1) begin
      m_dlc = dat[1];
      m_mie = dat[0];
    end
    m_iackq = iack;
  endtask

  task automatic set(logic e, logic r, logic a, logic d, logic w,
                     logic [1:0] o, logic [1:0] dd);
    @(negedge clk);
    ein = e; req = r; iack = a; rd = d; we = w; op = o; dat = dd;
    #1;
  endtask

  task automatic tick();
    auto_check();
    @(posedge clk);
    model_update();
  endtask

  task automatic step(logic e, logic r, logic a, logic d, logic w,
                      logic [1:0] o, logic [1:0] dd);
    set(e, r, a, d, w, o, dd);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG_CYC && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed);
    ein = 1'b1;
    #(3*CLK_PERIOD + 2);
    // R1 reset state
    chk("R1", "eout", eout, 1'b1);
    chk("R1", "int_n", int_n, 1'b1);
    chk("R1", "vec_oe", vec_oe, 1'b0);
    chk("R1", "ius", ius, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // idle table
    set(0,0,0,0,0,2'd0,2'd0); chk("R2", "eout", eout, 1'b0); tick();
    set(1,0,0,0,0,2'd0,2'd0); chk("R3", "eout", eout, 1'b1); tick();
    step(1,1,0,0,1,2'd1,2'b01);                      // pending + master enable
    set(1,0,0,0,0,2'd0,2'd0); chk("R3", "eout pend", eout, 1'b1);
    chk("R7", "int_n", int_n, 1'b0); tick();
    set(0,0,0,0,0,2'd0,2'd0); chk("R7", "int_n ein0", int_n, 1'b1); tick();

    // ack table, no response while ein low
    set(0,0,1,1,0,2'd0,2'd0); chk("R5", "eout", eout, 1'b0);
    chk("R5", "vec_oe", vec_oe, 1'b0); tick();
    step(0,0,0,0,0,2'd0,2'd0);
    set(1,0,0,0,0,2'd0,2'd0); chk("R5", "ius", ius, 1'b0); tick();

    // acknowledged cycle
    set(1,0,1,0,0,2'd0,2'd0); chk("R4", "eout pend", eout, 1'b0); tick();
    set(1,0,1,1,0,2'd0,2'd0); chk("R8", "vec_oe", vec_oe, 1'b1); tick();
    set(1,0,1,0,0,2'd0,2'd0); chk("R9", "ius mid", ius, 1'b0); tick();
    set(1,0,0,0,0,2'd0,2'd0); chk("R9", "ius end", ius, 1'b0); tick();
    set(1,0,0,0,0,2'd0,2'd0); chk("R9", "ius set", ius, 1'b1);
    chk("R3", "eout ius", eout, 1'b0); chk("R7", "int_n ius", int_n, 1'b1); tick();
    step(1,0,0,0,1,2'd3,2'd0);                       // clear pending, ius holds
    set(1,0,1,0,0,2'd0,2'd0); chk("R4", "eout ius", eout, 1'b0);
    chk("R10", "ius hold", ius, 1'b1); tick();
    step(1,0,0,0,0,2'd0,2'd0);
    step(1,0,0,0,1,2'd2,2'd0);                       // reset service
    set(1,0,0,0,0,2'd0,2'd0); chk("R10", "ius clr", ius, 1'b0);
    chk("R3", "eout", eout, 1'b1); tick();

    // pending frozen during ack
    set(1,0,1,0,0,2'd0,2'd0); chk("R4", "eout clear", eout, 1'b1); tick();
    step(1,1,1,0,0,2'd0,2'd0);
    set(1,0,1,1,0,2'd0,2'd0); chk("R12", "eout frozen", eout, 1'b1);
    chk("R12", "vec frozen", vec_oe, 1'b0); tick();
    step(1,1,0,0,0,2'd0,2'd0);                       // request lands now
    set(1,0,0,0,0,2'd0,2'd0); chk("R11", "int_n set", int_n, 1'b0); tick();
    step(1,0,1,0,1,2'd3,2'd0);                       // clear during ack ignored
    set(1,0,0,0,0,2'd0,2'd0); chk("R12", "int_n kept", int_n, 1'b0); tick();
    step(1,1,0,0,1,2'd3,2'd0);                       // request beats clear
    set(1,0,0,0,0,2'd0,2'd0); chk("R11", "req wins", int_n, 1'b0); tick();
    step(1,0,0,0,1,2'd0,2'd0);                       // nop
    set(1,0,0,0,0,2'd0,2'd0); chk("R11", "nop", int_n, 1'b0); tick();
    step(1,0,0,0,1,2'd3,2'd0);
    set(1,0,0,0,0,2'd0,2'd0); chk("R11", "cleared", int_n, 1'b1); tick();

    // downstream disable
    step(1,0,0,0,1,2'd1,2'b10);
    set(1,0,0,0,0,2'd0,2'd0); chk("R6", "eout idle", eout, 1'b0); tick();
    set(1,0,1,0,0,2'd0,2'd0); chk("R6", "eout ack", eout, 1'b0); tick();
    step(1,0,0,0,1,2'd1,2'b00);
    set(1,0,0,0,0,2'd0,2'd0); chk("R6", "eout restored", eout, 1'b1); tick();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic e, q, a, d, w;
      logic [1:0] o, dd;
      r  = $urandom;
      e  = (r[2:0] != 3'd0);
      q  = (r[5:3] == 3'd0);
      a  = (r[7:6] == 2'd0) ? ~iack : iack;
      d  = a && r[8];
      w  = (r[11:9] == 3'd0);
      o  = r[13:12];
      dd = {r[16:14] == 3'd0, r[17] | r[18]};
      step(e, q, a, d, w, o, dd);
    end
    step(1,0,0,0,0,2'd0,2'd0);
    finish_run();
  end
endmodule